// File: doc/BRIEF.md
# Shared Mailbox Array with Level Interrupts

This block holds a small array of shared mailboxes through which two processors pass messages over a plain 32-bit register bus. The producer writes a payload with the top bit set, which stores the value and marks the mailbox occupied in a single access. The consumer reads the payload and then writes zero to release the mailbox. When the wide option is built in, a mailbox can also carry four 32-bit data words and a tag word. Writing the tag with its top bit set marks that mailbox occupied.

Each mailbox raises an "empty" condition and a "full" condition. Both can be gated per mailbox. All the conditions are gathered into one read-only status word. Several shared interrupt lines each have their own 16-bit enable mask over that word, and each line is asserted for as long as any enabled status bit is set. A read-only configuration word reports the built counts. Reads return data one cycle after the request.

Top module: `hsmb_array`

## Requirements
- R1: After reset every mailbox register reads 0, each built mailbox reports empty, every interrupt enable mask is 0, and every interrupt line is low.
- R2: A write to a mailbox message word (mailbox offset 0x00) stores all 32 bits. If bit 31 of that write is 1, the mailbox becomes full: its full status bit goes to 1 and its empty status bit goes to 0.
- R3: Writing 0 to a message word clears both the payload and the full flag, so the mailbox reads 0 and reports empty again.
- R4: The status word at address 0x304 carries the empty bit of mailbox i at bit i (bits 7:0) and the full bit of mailbox i at bit 8+i (bits 15:8). Bits of mailboxes that are not built read 0, and writes to this address are ignored.
- R5: Interrupt line x has a 16-bit enable mask at address 0x100 + 4*x, which reads back as written. The line is 1 whenever any status bit ANDed with its mask bit is 1.
- R6: The interrupts are level-sensitive. An enabled empty bit keeps its line high on every cycle in which the mailbox stays empty, and the line drops in the cycle after a full-marking write.
- R7: Address 0x380 reads the configuration: mailbox count in bits 3:0, two auxiliary unit counts in bits 7:4 and 11:8, doorbell count in bits 15:12, and interrupt line count in bits 19:16, all taken from parameters.
- R8: With the wide option, data words at mailbox offsets 0x48, 0x4C, 0x50 and 0x54 and a tag at 0x40 read back as written. Data writes do not change the status. Writing the tag with bit 31 set makes the mailbox full, and writing 0 to the tag empties it again.
- R9: The per-mailbox enables for the full condition (offset 0x04, bit 0) and the empty condition (offset 0x08, bit 0) reset to 1 and read back as written. While an enable is 0, the matching status bit reads 0.
- R10: The registers of mailbox i start at byte address 0x10000 + i*0x8000. An access to one mailbox leaves all other mailboxes unchanged, and an address for a mailbox that is not built reads 0.
- R11: Read data appears on the read-data output in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | NUM_SI | Level-sensitive shared interrupt lines |

## Verification
The bench builds the block with six mailboxes and two interrupt lines, and turns on both the wide option and the per-mailbox enables. With six mailboxes, the status bits of the two unbuilt mailboxes and an address for an unbuilt mailbox can be checked for zero. With two lines, it can show that masks on different lines route different conditions. The auxiliary counts are set to distinct non-zero values, so a configuration field that is swapped or shifted shows up as a wrong word.

// File: rtl/hsmb_pkg.sv
package hsmb_pkg;

    localparam int ADDR_W   = 20;
    localparam int DATA_W   = 32;
    localparam int MAX_MB   = 8;
    localparam int STAT_W   = 2 * MAX_MB;
    localparam int WIDE_WORDS = 4;
    localparam int FULL_BIT = 31;

    localparam logic [ADDR_W-1:0] STAT_ADDR = 20'h00304;
    localparam logic [ADDR_W-1:0] DIM_ADDR  = 20'h00380;
    localparam logic [ADDR_W-1:0] MB_REGION = 20'h10000;
    localparam int                MB_SHIFT  = 15;

    localparam logic [14:0] OFF_MSG      = 15'h0000;
    localparam logic [14:0] OFF_FULL_IE  = 15'h0004;
    localparam logic [14:0] OFF_EMPTY_IE = 15'h0008;
    localparam logic [14:0] OFF_TAG      = 15'h0040;
    localparam logic [14:0] OFF_DATA0    = 15'h0048;

    typedef struct packed {
        logic        is_mb;
        logic [4:0]  slot;
        logic [14:0] off;
    } mb_dec_t;

    function automatic mb_dec_t mb_decode(logic [ADDR_W-1:0] a, int n_mb);
        mb_dec_t d;
        int blk;
        blk     = int'(a[ADDR_W-1:MB_SHIFT]);
        d.is_mb = (blk >= 2) && (blk < 2 + n_mb);
        d.slot  = 5'(blk - 2);
        d.off   = a[MB_SHIFT-1:0];
        return d;
    endfunction

    function automatic logic [ADDR_W-1:0] mb_addr(int idx, logic [14:0] off);
        return MB_REGION + ADDR_W'(idx << MB_SHIFT) + ADDR_W'(off);
    endfunction

    function automatic logic [DATA_W-1:0] dim_pack(int sm, int ss, int as_n, int db, int si);
        return {12'h000, 4'(si), 4'(db), 4'(as_n), 4'(ss), 4'(sm)};
    endfunction

endpackage

// File: rtl/hsmb_slot.sv
module hsmb_slot
    import hsmb_pkg::*;
#(
    parameter bit WIDE_EN  = 1'b1,
    parameter bit MB_IE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [14:0]       off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              msg_full,
    output logic              tag_full,
    output logic              empty_req,
    output logic              full_req
);

    logic [DATA_W-1:0] msg_q;
    logic [DATA_W-1:0] tag_q;
    logic [DATA_W-1:0] data_q [WIDE_WORDS];
    logic              ie_full_q;
    logic              ie_empty_q;

    always_ff @(posedge clk) begin
        if (rst) msg_q <= '0;
        else if (wr && off == OFF_MSG) msg_q <= wdata;
    end

    generate
        if (WIDE_EN) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst) begin
                    tag_q <= '0;
                    for (int k = 0; k < WIDE_WORDS; k++) data_q[k] <= '0;
                end else if (wr) begin
                    if (off == OFF_TAG) tag_q <= wdata;
                    for (int k = 0; k < WIDE_WORDS; k++)
                        if (off == 15'(OFF_DATA0 + 15'(4 * k))) data_q[k] <= wdata;
                end
            end
        end else begin : g_narrow
            assign tag_q = '0;
            for (genvar k = 0; k < WIDE_WORDS; k++) begin : g_z
                assign data_q[k] = '0;
            end
        end

        if (MB_IE_EN) begin : g_ie
            always_ff @(posedge clk) begin
                if (rst) begin
                    ie_full_q  <= 1'b1;
                    ie_empty_q <= 1'b1;
                end else if (wr) begin
                    if (off == OFF_FULL_IE)  ie_full_q  <= wdata[0];
                    if (off == OFF_EMPTY_IE) ie_empty_q <= wdata[0];
                end
            end
        end else begin : g_no_ie
            assign ie_full_q  = 1'b1;
            assign ie_empty_q = 1'b1;
        end
    endgenerate

    assign msg_full  = msg_q[FULL_BIT];
    assign tag_full  = tag_q[FULL_BIT];
    assign full_req  = (msg_full | tag_full) & ie_full_q;
    assign empty_req = ~(msg_full | tag_full) & ie_empty_q;

    always_comb begin
        rdata = '0;
        if (off == OFF_MSG)           rdata = msg_q;
        else if (off == OFF_TAG)      rdata = tag_q;
        else if (off == OFF_FULL_IE)  rdata = {31'b0, MB_IE_EN ? ie_full_q : 1'b0};
        else if (off == OFF_EMPTY_IE) rdata = {31'b0, MB_IE_EN ? ie_empty_q : 1'b0};
        for (int k = 0; k < WIDE_WORDS; k++)
            if (off == 15'(OFF_DATA0 + 15'(4 * k))) rdata = data_q[k];
    end

endmodule

// File: rtl/hsmb_irq.sv
module hsmb_irq
    import hsmb_pkg::*;
#(
    parameter int NUM_SI = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STAT_W-1:0] wdata,
    input  logic [STAT_W-1:0] stat,
    output logic [NUM_SI-1:0] irq,
    output logic              rd_hit,
    output logic [STAT_W-1:0] rd_data
);

    logic [STAT_W-1:0] ie_q [NUM_SI];
    logic [5:0]        idx;
    logic              in_region;

    assign idx       = addr[7:2];
    assign in_region = (addr[ADDR_W-1:8] == 12'h001) && (addr[1:0] == 2'b00);
    assign rd_hit    = in_region && (int'(idx) < NUM_SI);

    generate
        for (genvar x = 0; x < NUM_SI; x++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) ie_q[x] <= '0;
                else if (wr && in_region && idx == 6'(x)) ie_q[x] <= wdata;
            end
            assign irq[x] = |(stat & ie_q[x]);
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int x = 0; x < NUM_SI; x++)
            if (idx == 6'(x)) rd_data = ie_q[x];
    end

endmodule

// File: rtl/hsmb_array.sv
module hsmb_array
    import hsmb_pkg::*;
#(
    parameter int NUM_MB   = 8,
    parameter int NUM_SI   = 4,
    parameter int NUM_SS   = 0,
    parameter int NUM_AS   = 0,
    parameter int NUM_DB   = 0,
    parameter bit WIDE_EN  = 1'b1,
    parameter bit MB_IE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [19:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_SI-1:0] irq
);

    localparam logic [DATA_W-1:0] DIM_VAL = dim_pack(NUM_MB, NUM_SS, NUM_AS, NUM_DB, NUM_SI);

    mb_dec_t           dec;
    logic              wr;
    logic [DATA_W-1:0] slot_rd [NUM_MB];
    logic [NUM_MB-1:0] msg_full_vec;
    logic [NUM_MB-1:0] tag_full_vec;
    logic [NUM_MB-1:0] empty_vec;
    logic [NUM_MB-1:0] full_vec;
    logic [STAT_W-1:0] stat_word;
    logic              ie_hit;
    logic [STAT_W-1:0] ie_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    assign dec = mb_decode(bus_addr, NUM_MB);
    assign wr  = bus_en & bus_we;

    generate
        for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
            hsmb_slot #(.WIDE_EN(WIDE_EN), .MB_IE_EN(MB_IE_EN)) slot_i (
                .clk       (clk),
                .rst       (rst),
                .wr        (wr && dec.is_mb && dec.slot == 5'(i)),
                .off       (dec.off),
                .wdata     (bus_wdata),
                .rdata     (slot_rd[i]),
                .msg_full  (msg_full_vec[i]),
                .tag_full  (tag_full_vec[i]),
                .empty_req (empty_vec[i]),
                .full_req  (full_vec[i])
            );
        end
    endgenerate

    always_comb begin
        stat_word = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            stat_word[i]          = empty_vec[i];
            stat_word[MAX_MB + i] = full_vec[i];
        end
    end

    hsmb_irq #(.NUM_SI(NUM_SI)) irq_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata[STAT_W-1:0]),
        .stat    (stat_word),
        .irq     (irq),
        .rd_hit  (ie_hit),
        .rd_data (ie_rd)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == STAT_ADDR)     rd_mux = {16'h0, stat_word};
        else if (bus_addr == DIM_ADDR) rd_mux = DIM_VAL;
        else if (ie_hit)               rd_mux = {16'h0, ie_rd};
        else if (dec.is_mb) begin
            for (int i = 0; i < NUM_MB; i++)
                if (dec.slot == 5'(i)) rd_mux = slot_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else if (bus_en && !bus_we) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/hsmb_array_chk.sv
module hsmb_array_chk
    import hsmb_pkg::*;
#(
    parameter int NUM_MB  = 8,
    parameter int NUM_SI  = 4,
    parameter bit WIDE_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [19:0]       bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_SI-1:0] irq,
    input logic [STAT_W-1:0] stat_word,
    input logic [NUM_MB-1:0] msg_full_vec,
    input logic [NUM_MB-1:0] tag_full_vec
);

    logic wr;
    assign wr = bus_en && bus_we;

    // R2
    set_full_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == mb_addr(0, OFF_MSG) && bus_wdata[FULL_BIT]) |=> msg_full_vec[0]);

    // R3
    clear_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == mb_addr(0, OFF_MSG) && bus_wdata == 32'h0 && !tag_full_vec[0])
        |=> (!msg_full_vec[0] && stat_word[MAX_MB] == 1'b0));

    // R4
    stat_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == STAT_ADDR) |=> $stable(stat_word));

    generate
        for (genvar x = 0; x < NUM_SI; x++) begin : g_lvl
            // R6
            level_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (irq[x] && !wr) |=> irq[x]);
        end
        if (NUM_MB > 1) begin : g_iso
            // R10
            mb_isolation_chk: assert property (@(posedge clk) disable iff (rst)
                (wr && bus_addr == mb_addr(0, OFF_MSG)) |=> $stable(msg_full_vec[1]));
        end
        if (WIDE_EN) begin : g_tag
            // R8
            tag_full_chk: assert property (@(posedge clk) disable iff (rst)
                (wr && bus_addr == mb_addr(0, OFF_TAG) && bus_wdata[FULL_BIT]) |=> tag_full_vec[0]);
        end
    endgenerate

endmodule

bind hsmb_array hsmb_array_chk #(
    .NUM_MB  (NUM_MB),
    .NUM_SI  (NUM_SI),
    .WIDE_EN (WIDE_EN)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .irq          (irq),
    .stat_word    (stat_word),
    .msg_full_vec (msg_full_vec),
    .tag_full_vec (tag_full_vec)
);

// File: tb/hsmb_array_tb_top.sv
module hsmb_array_tb_top;
    import hsmb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NMB = 6;
    localparam int NSI = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NSI-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsmb_array #(
        .NUM_MB(NMB), .NUM_SI(NSI), .NUM_SS(1), .NUM_AS(2), .NUM_DB(9),
        .WIDE_EN(1'b1), .MB_IE_EN(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // monitor: a read issued at one edge is compared at the following negedge
    always @(posedge clk) pend <= bus_en & ~bus_we;

    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [19:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(logic [19:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_en = 1'b0; bus_we = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        rd(STAT_ADDR, 32'h0000_003F, "R1 status");
        rd(mb_addr(0, OFF_MSG), 32'h0, "R1 msg0");
        rd(20'h00100, 32'h0, "R1 ie0");
        // R7 configuration word
        rd(DIM_ADDR, 32'h0002_9216, "R7 dim");
        idle(1);

        // R2 full-marking write
        wr(mb_addr(2, OFF_MSG), 32'h8000_1234);
        rd(mb_addr(2, OFF_MSG), 32'h8000_1234, "R2 msg2");
        rd(STAT_ADDR, 32'h0000_043B, "R2 status");
        // R10 neighbours untouched, unbuilt slot reads 0
        rd(mb_addr(1, OFF_MSG), 32'h0, "R10 msg1");
        rd(mb_addr(3, OFF_MSG), 32'h0, "R10 msg3");
        rd(mb_addr(6, OFF_MSG), 32'h0, "R10 unbuilt");

        // R5 line routing
        wr(20'h00104, 32'h0000_0400);
        idle(1);
        check("R5 irq full2 on line1", 32'(irq), 32'h2);
        rd(20'h00104, 32'h0000_0400, "R5 ie1 readback");

        // R3 release
        wr(mb_addr(2, OFF_MSG), 32'h0);
        idle(1);
        check("R3 irq after release", 32'(irq), 32'h0);
        rd(mb_addr(2, OFF_MSG), 32'h0, "R3 msg2");
        rd(STAT_ADDR, 32'h0000_003F, "R3 status");

        // R6 level behaviour of empty condition
        wr(20'h00100, 32'h0000_0001);
        idle(1);
        check("R6 irq empty0", 32'(irq), 32'h1);
        idle(5);
        check("R6 irq held", 32'(irq), 32'h1);
        wr(mb_addr(0, OFF_MSG), 32'h8000_0005);
        idle(1);
        check("R6 irq drop on full", 32'(irq), 32'h0);
        wr(mb_addr(0, OFF_MSG), 32'h0);
        idle(1);
        check("R6 irq back on empty", 32'(irq), 32'h1);
        wr(20'h00100, 32'h0);
        idle(1);
        check("R5 irq masked", 32'(irq), 32'h0);

        // R4 status ignores writes
        wr(STAT_ADDR, 32'h0000_FFFF);
        rd(STAT_ADDR, 32'h0000_003F, "R4 status after write");

        // R8 wide mode
        for (int k = 0; k < 4; k++)
            wr(mb_addr(4, 15'(OFF_DATA0 + 15'(4 * k))), 32'h11 * (k + 1));
        for (int k = 0; k < 4; k++)
            rd(mb_addr(4, 15'(OFF_DATA0 + 15'(4 * k))), 32'h11 * (k + 1), "R8 data");
        rd(STAT_ADDR, 32'h0000_003F, "R8 data no full");
        wr(mb_addr(4, OFF_TAG), 32'h8000_0000);
        rd(mb_addr(4, OFF_TAG), 32'h8000_0000, "R8 tag");
        rd(STAT_ADDR, 32'h0000_102F, "R8 tag full");
        wr(mb_addr(4, OFF_TAG), 32'h0);
        rd(STAT_ADDR, 32'h0000_003F, "R8 tag clear");

        // R9 per-mailbox enables
        rd(mb_addr(5, OFF_FULL_IE), 32'h1, "R9 full ie reset");
        wr(mb_addr(5, OFF_FULL_IE), 32'h0);
        wr(mb_addr(5, OFF_MSG), 32'h8000_0000);
        rd(mb_addr(5, OFF_FULL_IE), 32'h0, "R9 full ie readback");
        rd(STAT_ADDR, 32'h0000_001F, "R9 full gated");
        wr(mb_addr(5, OFF_EMPTY_IE), 32'h0);
        wr(mb_addr(5, OFF_MSG), 32'h0);
        rd(STAT_ADDR, 32'h0000_001F, "R9 empty gated");
        wr(mb_addr(5, OFF_EMPTY_IE), 32'h1);
        wr(mb_addr(5, OFF_FULL_IE), 32'h1);
        rd(STAT_ADDR, 32'h0000_003F, "R9 restored");

        // R11 read data holds through idle cycles
        rd(DIM_ADDR, 32'h0002_9216, "R11 read");
        idle(3);
        check("R11 hold", bus_rdata, 32'h0002_9216);

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule